// File: doc/BRIEF.md
# Three-Bit JK Sequence Counter

This block is a 3-bit synchronous Moore counter whose value comes straight from three rising-edge JK flip-flops. It does not count in binary. From reset it steps through the repeating cycle 1, 4, 2, 7. Each J/K pair is driven by a minimised excitation equation that depends only on the top bit of the present state. The output is the flip-flop outputs themselves, with no decoding after them.

The four codes outside the cycle (0, 3, 5, 6) were treated as don't-cares when the equations were minimised. As a result they form a closed ring of their own, and the counter keeps this lockout on purpose. The code loaded by reset is a parameter whose default is 1. This lets a test harness start an instance on an unused code through the ordinary reset path, with no load port.

Top module: `jk_seq_counter`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, `count` takes the value of parameter RESET_CODE (default 1) at that edge, whatever the present state is.
- R2: From 1 (binary 001), the next edge without reset gives 4 (100).
- R3: From 4 (100), the next edge without reset gives 2 (010).
- R4: From 2 (010), the next edge without reset gives 7 (111).
- R5: From 7 (111), the next edge without reset gives 1 (001).
- R6: Bit 2 of `count` (the MSB) inverts on every edge without reset.
- R7: Bit 1 of `count` inverts on an edge exactly when bit 2 was 1 before that edge. Bit 0 inverts exactly when bit 2 was 0 before that edge. Otherwise each of them holds its value.
- R8: From an unused code, the counter follows 0 → 5 → 3 → 6 → 0 and never reaches 1, 2, 4 or 7.
- R9: From any of the codes 1, 2, 4 and 7, the counter never reaches an unused code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; loads RESET_CODE |
| count | output | 3 | Counter state, taken directly from the flip-flops; bit 2 is the MSB |

## Verification
The main cycle is run from reset for more than three full periods. Every edge is compared with a model of the 1, 4, 2, 7 order, which tells a wrong excitation equation apart from a wrong starting code. Four further instances start on 0, 3, 5 and 6. Each one must stay inside the 0, 5, 3, 6 ring for two laps, so a design that escapes to the main cycle, or that would fix the lockout, is caught. A reset asserted in the middle of a run must bring the counter back to 1 at once. This shows that reset wins over the JK toggles.

// File: rtl/jk_seq_pkg.sv
package jk_seq_pkg;
  localparam int unsigned Width = 3;
  localparam int unsigned MsbIdx = Width - 1;

  typedef logic [Width-1:0] code_t;

  // excitation strobes passed from control to datapath
  typedef struct packed {
    code_t jIn;
    code_t kIn;
  } jkStrobe_t;
endpackage

// File: rtl/jk_seq_ctrl.sv
module jk_seq_ctrl
  import jk_seq_pkg::*;
(
  input  code_t     curState,
  output jkStrobe_t strobes
);
  logic msb;
  assign msb = curState[MsbIdx];

  always_comb begin
    // bit 2: J = K = 1 ; bit 1: J = K = msb ; bit 0: J = K = ~msb
    strobes.jIn = {1'b1, msb, ~msb};
    strobes.kIn = {1'b1, msb, ~msb};
  end
endmodule

// File: rtl/jk_seq_dp.sv
module jk_seq_dp
  import jk_seq_pkg::*;
#(
  parameter code_t RESET_CODE = 3'd1
) (
  input  logic      clk,
  input  logic      rst,
  input  jkStrobe_t strobes,
  output code_t     curState
);
  for (genvar i = 0; i < Width; i++) begin : gBit
    logic bitQ;
    always_ff @(posedge clk) begin
      if (rst) bitQ <= RESET_CODE[i];
      else begin
        case ({strobes.jIn[i], strobes.kIn[i]})
          2'b00:   bitQ <= bitQ;
          2'b01:   bitQ <= 1'b0;
          2'b10:   bitQ <= 1'b1;
          default: bitQ <= ~bitQ;
        endcase
      end
    end
    assign curState[i] = bitQ;
  end

  function automatic logic isMain(input code_t c);
    return (c == 3'd1) || (c == 3'd2) || (c == 3'd4) || (c == 3'd7);
  endfunction

  p_reset_load_r1: assert property (@(posedge clk) rst |=> curState == RESET_CODE);
  p_step_1_r2:  assert property (@(posedge clk) disable iff (rst) curState == 3'd1 |=> curState == 3'd4);
  p_step_4_r3:  assert property (@(posedge clk) disable iff (rst) curState == 3'd4 |=> curState == 3'd2);
  p_step_2_r4:  assert property (@(posedge clk) disable iff (rst) curState == 3'd2 |=> curState == 3'd7);
  p_step_7_r5:  assert property (@(posedge clk) disable iff (rst) curState == 3'd7 |=> curState == 3'd1);
  p_msb_toggle_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> curState[2] != $past(curState[2]));
  p_mid_toggle_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (curState[1] != $past(curState[1])) == $past(curState[2]));
  p_low_toggle_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (curState[0] != $past(curState[0])) == !$past(curState[2]));
  p_lock_ring_r8: assert property (@(posedge clk) disable iff (rst)
    !isMain(curState) |=> !isMain(curState));
  p_main_closed_r9: assert property (@(posedge clk) disable iff (rst)
    isMain(curState) |=> isMain(curState));
endmodule

// File: rtl/jk_seq_counter.sv
module jk_seq_counter
  import jk_seq_pkg::*;
#(
  parameter code_t RESET_CODE = 3'd1
) (
  input  logic       clk,
  input  logic       rst,
  output logic [2:0] count
);
  jkStrobe_t strobes;
  code_t     curState;

  jk_seq_ctrl uCtrl (
    .curState (curState),
    .strobes  (strobes)
  );

  jk_seq_dp #(.RESET_CODE(RESET_CODE)) uDp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .curState (curState)
  );

  assign count = curState;
endmodule

// File: tb/sim_jk_seq_counter.sv
module sim_jk_seq_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] count;
  logic [2:0] lockCount [4];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  jk_seq_counter u0 (.clk(clk), .rst(rst), .count(count));
  jk_seq_counter #(.RESET_CODE(3'd0)) uLock0 (.clk(clk), .rst(rst), .count(lockCount[0]));
  jk_seq_counter #(.RESET_CODE(3'd3)) uLock3 (.clk(clk), .rst(rst), .count(lockCount[1]));
  jk_seq_counter #(.RESET_CODE(3'd5)) uLock5 (.clk(clk), .rst(rst), .count(lockCount[2]));
  jk_seq_counter #(.RESET_CODE(3'd6)) uLock6 (.clk(clk), .rst(rst), .count(lockCount[3]));

  // reference: main cycle 1,4,2,7 and lockout ring 0,5,3,6
  function automatic logic [2:0] refNext(input logic [2:0] c);
    case (c)
      3'd1: return 3'd4;
      3'd4: return 3'd2;
      3'd2: return 3'd7;
      3'd7: return 3'd1;
      3'd0: return 3'd5;
      3'd5: return 3'd3;
      3'd3: return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic isMain(input logic [2:0] c);
    return (c == 3'd1) || (c == 3'd2) || (c == 3'd4) || (c == 3'd7);
  endfunction

  task automatic checkEq(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic stepEdge();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    rst = 1'b1;
    stepEdge();
    stepEdge();
    checkEq("R1 main reset", count, 3'd1);
    checkEq("R1 lock0 reset", lockCount[0], 3'd0);
    checkEq("R1 lock3 reset", lockCount[1], 3'd3);
    checkEq("R1 lock5 reset", lockCount[2], 3'd5);
    checkEq("R1 lock6 reset", lockCount[3], 3'd6);
  endtask

  task automatic testMainCycle();
    logic [2:0] expVal = 3'd1;
    logic [2:0] prev;
    rst = 1'b0;
    for (int n = 0; n < 16; n++) begin
      prev = expVal;
      expVal = refNext(prev);
      stepEdge();
      case (prev)
        3'd1: checkEq("R2 1->4", count, expVal);
        3'd4: checkEq("R3 4->2", count, expVal);
        3'd2: checkEq("R4 2->7", count, expVal);
        default: checkEq("R5 7->1", count, expVal);
      endcase
      checkEq("R6 msb toggles", {2'b0, count[2]}, {2'b0, ~prev[2]});
      checkEq("R7 mid bit", {2'b0, count[1]}, {2'b0, prev[1] ^ prev[2]});
      checkEq("R7 low bit", {2'b0, count[0]}, {2'b0, prev[0] ^ ~prev[2]});
      checkEq("R9 stays in main", {2'b0, isMain(count)}, 3'd1);
      // lockout instances step in parallel
      for (int u = 0; u < 4; u++) begin
        checkEq("R8 lockout stays in ring", {2'b0, isMain(lockCount[u])}, 3'd0);
      end
    end
  endtask

  task automatic testLockoutRing();
    logic [2:0] expL [4];
    rst = 1'b1;
    stepEdge();
    expL[0] = 3'd0; expL[1] = 3'd3; expL[2] = 3'd5; expL[3] = 3'd6;
    rst = 1'b0;
    for (int n = 0; n < 8; n++) begin
      for (int u = 0; u < 4; u++) expL[u] = refNext(expL[u]);
      stepEdge();
      for (int u = 0; u < 4; u++) checkEq("R8 lockout ring order", lockCount[u], expL[u]);
    end
  endtask

  task automatic testMidReset();
    rst = 1'b0;
    stepEdge();
    stepEdge();   // main counter now at 2 after re-reset path; not 1
    checkEq("R3 after mid-run steps", count, 3'd2);
    rst = 1'b1;
    stepEdge();
    checkEq("R1 reset overrides toggles", count, 3'd1);
    checkEq("R1 lock reset overrides", lockCount[2], 3'd5);
    rst = 1'b0;
    stepEdge();
    checkEq("R2 resume after reset", count, 3'd4);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testMainCycle();
    testLockoutRing();
    rst = 1'b1;
    stepEdge();
    testMidReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule